// File: doc/BRIEF.md
# Serial EEPROM Configuration Bridge

This block sits behind a configuration-space access port and lets software bit-bang a three-wire serial EEPROM of 64 sixteen-bit words. A write to one dedicated configuration dword raises the EEPROM select line and sets the serial clock and serial input from two bits of the written data. A write to a second dedicated dword drops all three lines. The EEPROM's serial output is visible to software only indirectly: a single-byte configuration read of offset 0 returns zero whenever that line is low. Every other configuration dword is an ordinary storage register.

The EEPROM is modelled inside the block as a read-only device. Right after reset, a loader fills its word memory with a fixed default image, one word per clock. While it does so it adds up the words. It then writes a final sealing word chosen so that the sum of all 64 little-endian words equals 0x1234. A flag reports when the image is in place. The serial side decodes the usual read sequence: a start bit, a two-bit opcode, a six-bit word address, a dummy zero and then sixteen data bits with the most significant bit first.

Top module: `seeprom_cfg_bridge`

## Requirements
- R1: While reset is high and on the cycle after it, the select, clock and serial-input pins are 0, the read-valid and image-ready outputs are 0 and the serial output is 1.
- R2: A write to dword 0x80 (address bits 7:2 equal to 32) sets the select pin to 1, the clock pin to data bit 7 and the serial-input pin to data bit 6 from the next cycle on.
- R3: A write to dword 0xC0 (address bits 7:2 equal to 48) drives select, clock and serial input to 0 from the next cycle on.
- R4: A byte read (cfg_rd_byte = 1) at address 0x00 returns 0 in bits 7:0 when the serial output is 0 in the request cycle, and the stored byte otherwise. Every read response appears one cycle after the request, with cfg_rvalid high for that one cycle.
- R5: Writes to any other dword store the full 32-bit data. A word read returns that dword. A byte read returns the byte at address bits 1:0 (little-endian) in bits 7:0 and zeros above. Both pin dwords read as 0, and writes to them leave the storage unchanged.
- R6: image_ready rises on the 64th clock after reset is released and then stays high. The image has words 0 to 15 equal to 0x0057, byte 64 = 0x07, byte 65 = 0x0F, byte 67 = 0x04 and byte 68 = 0x07, with all other bytes 0 apart from the sealing word.
- R7: Word 63 holds 0x1234 minus the 16-bit sum of words 0 to 62 (0xF9B6 for the default image), so the 16-bit sum of all 64 words is 0x1234.
- R8: With select high, each rising edge of the clock pin shifts in one bit. After a 1 start bit, opcode 10 and six address bits (MSB first), the serial output goes to 0 (the dummy bit). The next 16 rising edges present the word's bits 15 down to 0, and the edge after those sets it back to 1. The serial output changes one cycle after the configuration write that raised the clock pin.
- R9: While select is low the serial output is 1 and the decoder waits for a new start bit. A command whose opcode is not 10 leaves the output at 1 until select drops.
- R10: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rd_byte | input | 1 | Read returns one byte instead of a dword |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read response data |
| cfg_rvalid | output | 1 | Read response valid |
| ee_cs | output | 1 | EEPROM select line |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial input |
| ee_do | output | 1 | EEPROM serial output |
| image_ready | output | 1 | Default image and seal are written |

## Verification
The pin lines are due one clock after the write that sets them. The serial output is due one clock later still, because the decoder sees the clock pin through its own register. Read responses are due one clock after the request, and image_ready on the 64th clock after reset release. The bench applies every stimulus on the falling edge and steps a behavioural model on the same rising edge as the design. It then compares every output with the model on the next falling edge, so each result is checked in exactly the cycle it becomes due. Explicit checks on fixed constants (the seal word, the word sum, the gated byte) sit on top of this model comparison.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [15:0] SEAL_TARGET = 16'h1234;
  localparam logic [1:0]  OP_READ     = 2'b10;

  typedef enum logic [1:0] {
    SS_IDLE,
    SS_CMD,
    SS_DATA,
    SS_HOLD
  } ser_state_e;

  // Default byte of the power-up image (the seal word is handled by the loader)
  function automatic logic [7:0] default_byte(input int unsigned idx);
    logic [7:0] b;
    b = 8'h00;
    if (idx < 32 && (idx % 2) == 0) b = 8'h57;
    case (idx)
      64:      b = 8'h07;
      65:      b = 8'h0F;
      67:      b = 8'h04;
      68:      b = 8'h07;
      default: ;
    endcase
    return b;
  endfunction

  function automatic logic [15:0] default_word(input int unsigned w);
    return {default_byte(2 * w + 1), default_byte(2 * w)};
  endfunction

endpackage

// File: rtl/seeprom_word_ram.sv
module seeprom_word_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seeprom_image_loader.sv
module seeprom_image_loader #(
  parameter int            AW     = 6,
  parameter int            DW     = 16,
  parameter logic [DW-1:0] TARGET = seeprom_pkg::SEAL_TARGET
) (
  input  logic          clk,
  input  logic          rst,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          ready
);
  localparam int            WORDS = 1 << AW;
  localparam logic [AW-1:0] LAST  = AW'(WORDS - 1);

  logic [AW-1:0] idx_q;
  logic [DW-1:0] sum_q;
  logic [DW-1:0] word_c;

  always_comb begin
    word_c = DW'(seeprom_pkg::default_word(32'(idx_q)));
    wdata  = (idx_q == LAST) ? (TARGET - sum_q) : word_c;
  end

  assign we    = !ready;
  assign waddr = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sum_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      sum_q <= sum_q + wdata;
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) ready <= 1'b1;
    end
  end

  // R6: once the image is sealed the flag never drops until reset
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

endmodule

// File: rtl/seeprom_serial_slave.sv
module seeprom_serial_slave #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          sk,
  input  logic          si,
  output logic [AW-1:0] raddr,
  input  logic [DW-1:0] rword,
  output logic          so
);
  import seeprom_pkg::*;

  localparam int CMDW = AW + 2;
  localparam int MAXB = (CMDW > DW) ? CMDW : DW;
  localparam int CNTW = $clog2(MAXB + 1);

  ser_state_e      state_q;
  logic            sk_d;
  logic [CNTW-1:0] cnt_q;
  logic [CMDW-2:0] cmd_q;
  logic [CMDW-1:0] cmd_next;
  logic [DW-1:0]   shreg_q;
  logic [DW-1:0]   word_src;
  logic [AW-1:0]   addr_q;
  logic            so_q;
  logic            rise;

  assign rise     = sk && !sk_d;
  assign cmd_next = {cmd_q, si};
  assign word_src = (cnt_q == '0) ? rword : shreg_q;
  assign raddr    = addr_q;
  assign so       = so_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SS_IDLE;
      sk_d    <= 1'b0;
      cnt_q   <= '0;
      cmd_q   <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      so_q    <= 1'b1;
    end else begin
      sk_d <= sk;
      if (!cs) begin
        state_q <= SS_IDLE;
        cnt_q   <= '0;
        so_q    <= 1'b1;
      end else if (rise) begin
        case (state_q)
          SS_IDLE: begin
            if (si) begin
              state_q <= SS_CMD;
              cnt_q   <= '0;
              cmd_q   <= '0;
            end
          end
          SS_CMD: begin
            cmd_q <= cmd_next[CMDW-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNTW'(CMDW - 1)) begin
              cnt_q <= '0;
              if (cmd_next[CMDW-1 -: 2] == OP_READ) begin
                addr_q  <= cmd_next[AW-1:0];
                so_q    <= 1'b0;
                state_q <= SS_DATA;
              end else begin
                state_q <= SS_HOLD;
              end
            end
          end
          SS_DATA: begin
            if (cnt_q < CNTW'(DW)) begin
              so_q    <= word_src[DW-1];
              shreg_q <= {word_src[DW-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
            end else begin
              so_q    <= 1'b1;
              state_q <= SS_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: a deselected device drives its output high on the next cycle
  a_r9_deselect_high: assert property (@(posedge clk) disable iff (rst)
    !cs |=> so);

  // R9: a clock edge with select low never starts a command
  a_r9_no_decode_idle: assert property (@(posedge clk) disable iff (rst)
    (!cs && rise) |=> (state_q == SS_IDLE));

endmodule

// File: rtl/seeprom_cfg_port.sv
module seeprom_cfg_port #(
  parameter int             CAW       = 8,
  parameter int             CDW       = 32,
  parameter logic [CAW-1:0] DRIVE_OFS = 8'h80,
  parameter logic [CAW-1:0] DROP_OFS  = 8'hC0,
  parameter logic [CAW-1:0] GATE_OFS  = 8'h00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           rd,
  input  logic           rd_byte,
  input  logic [CAW-1:0] addr,
  input  logic [CDW-1:0] wdata,
  input  logic           so_in,
  output logic           cs,
  output logic           sk,
  output logic           si,
  output logic [CDW-1:0] rdata,
  output logic           rvalid
);
  localparam int IDXW  = CAW - 2;
  localparam int DEPTH = 1 << IDXW;

  logic [CDW-1:0]  regs [DEPTH];
  logic [IDXW-1:0] idx;
  logic            hit_drive;
  logic            hit_drop;
  logic [CDW-1:0]  word_c;
  logic [7:0]      byte_c;

  assign idx       = addr[CAW-1:2];
  assign hit_drive = (idx == DRIVE_OFS[CAW-1:2]);
  assign hit_drop  = (idx == DROP_OFS[CAW-1:2]);

  always_ff @(posedge clk) begin
    if (wr && !hit_drive && !hit_drop) regs[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= 1'b0;
      sk <= 1'b0;
      si <= 1'b0;
    end else if (wr && hit_drive) begin
      cs <= 1'b1;
      sk <= wdata[7];
      si <= wdata[6];
    end else if (wr && hit_drop) begin
      cs <= 1'b0;
      sk <= 1'b0;
      si <= 1'b0;
    end
  end

  always_comb begin
    word_c = (hit_drive || hit_drop) ? '0 : regs[idx];
    byte_c = word_c[{addr[1:0], 3'b000} +: 8];
    if (addr == GATE_OFS && !so_in) byte_c = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_byte ? CDW'(byte_c) : word_c;
    end
  end

  a_r2_drive_pins: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_drive) |=> (cs && sk == $past(wdata[7]) && si == $past(wdata[6])));

  a_r3_drop_pins: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_drop) |=> (!cs && !sk && !si));

  a_r4_gated_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && rd_byte && addr == GATE_OFS && !so_in) |=> (rdata == '0));

  a_r4_resp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

endmodule

// File: rtl/seeprom_cfg_bridge.sv
module seeprom_cfg_bridge #(
  parameter int CAW   = 8,
  parameter int CDW   = 32,
  parameter int EE_AW = 6,
  parameter int EE_DW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic           cfg_rd_byte,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CDW-1:0] cfg_wdata,
  output logic [CDW-1:0] cfg_rdata,
  output logic           cfg_rvalid,
  output logic           ee_cs,
  output logic           ee_sk,
  output logic           ee_di,
  output logic           ee_do,
  output logic           image_ready
);
  logic             ld_we;
  logic [EE_AW-1:0] ld_addr;
  logic [EE_DW-1:0] ld_data;
  logic [EE_AW-1:0] rd_addr;
  logic [EE_DW-1:0] rd_word;

  seeprom_image_loader #(.AW(EE_AW), .DW(EE_DW)) u_loader (
    .clk   (clk),
    .rst   (rst),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .ready (image_ready)
  );

  seeprom_word_ram #(.AW(EE_AW), .DW(EE_DW)) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  seeprom_serial_slave #(.AW(EE_AW), .DW(EE_DW)) u_slave (
    .clk   (clk),
    .rst   (rst),
    .cs    (ee_cs),
    .sk    (ee_sk),
    .si    (ee_di),
    .raddr (rd_addr),
    .rword (rd_word),
    .so    (ee_do)
  );

  seeprom_cfg_port #(.CAW(CAW), .CDW(CDW)) u_port (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .rd      (cfg_rd),
    .rd_byte (cfg_rd_byte),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .so_in   (ee_do),
    .cs      (ee_cs),
    .sk      (ee_sk),
    .si      (ee_di),
    .rdata   (cfg_rdata),
    .rvalid  (cfg_rvalid)
  );

  // R6: the loader's write port stays quiet once the image is reported ready
  a_r6_ram_frozen: assert property (@(posedge clk) disable iff (rst)
    image_ready |=> !ld_we);

endmodule

// File: tb/sim_seeprom_cfg_bridge.sv
module sim_seeprom_cfg_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_rd_byte = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid, ee_cs, ee_sk, ee_di, ee_do, image_ready;

  seeprom_cfg_bridge u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rd_byte(cfg_rd_byte),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do), .image_ready(image_ready)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- expected image, built from the requirements -------------
  logic [15:0] img [64];
  function automatic logic [7:0] ref_byte(input int i);
    if (i == 64 || i == 68) return 8'h07;
    if (i == 65) return 8'h0F;
    if (i == 67) return 8'h04;
    if (i < 32 && (i % 2) == 0) return 8'h57;
    return 8'h00;
  endfunction
  initial begin
    logic [15:0] s;
    s = 16'h0;
    for (int w = 0; w < 63; w++) begin
      img[w] = {ref_byte(2 * w + 1), ref_byte(2 * w)};
      s = s + img[w];
    end
    img[63] = 16'h1234 - s;
  end

  // ---------------- behavioural model, stepped on the rising edge -----------
  logic        m_cs, m_sk, m_di, m_skd, m_do, m_ready, m_rvalid;
  logic [31:0] m_rdata;
  string       m_rtag;
  logic [31:0] m_cfg [64];
  int          m_cycles, m_st, m_cnt;
  logic [7:0]  m_cmd;
  logic [15:0] m_word;

  always @(posedge clk) begin : model
    logic [7:0]  nc;
    logic [31:0] w;
    logic [7:0]  b;
    if (rst) begin
      m_cs <= 0; m_sk <= 0; m_di <= 0; m_skd <= 0; m_do <= 1;
      m_ready <= 0; m_rvalid <= 0; m_rdata <= 0; m_cycles <= 0;
      m_st <= 0; m_cnt <= 0; m_cmd <= 0; m_word <= 0; m_rtag <= "R4";
    end else begin
      m_cycles <= m_cycles + 1;
      if (m_cycles >= 63) m_ready <= 1;
      // serial decoder sees the pins as they stood before this edge
      m_skd <= m_sk;
      if (!m_cs) begin
        m_st <= 0; m_do <= 1;
      end else if (m_sk && !m_skd) begin
        case (m_st)
          0: if (m_di) begin m_st <= 1; m_cnt <= 0; m_cmd <= 0; end
          1: begin
            nc = {m_cmd[6:0], m_di};
            m_cmd <= nc;
            m_cnt <= m_cnt + 1;
            if (m_cnt == 7) begin
              m_cnt <= 0;
              if (nc[7:6] == 2'b10) begin m_word <= img[nc[5:0]]; m_do <= 0; m_st <= 2; end
              else m_st <= 3;
            end
          end
          2: if (m_cnt < 16) begin m_do <= m_word[15 - m_cnt]; m_cnt <= m_cnt + 1; end
             else begin m_do <= 1; m_st <= 3; end
          default: ;
        endcase
      end
      if (cfg_wr) begin
        if (cfg_addr[7:2] == 6'd32) begin m_cs <= 1; m_sk <= cfg_wdata[7]; m_di <= cfg_wdata[6]; end
        else if (cfg_addr[7:2] == 6'd48) begin m_cs <= 0; m_sk <= 0; m_di <= 0; end
        else m_cfg[cfg_addr[7:2]] <= cfg_wdata;
      end
      m_rvalid <= cfg_rd;
      if (cfg_rd) begin
        w = (cfg_addr[7:2] == 6'd32 || cfg_addr[7:2] == 6'd48) ? 32'h0 : m_cfg[cfg_addr[7:2]];
        if (cfg_rd_byte) begin
          b = 8'(w >> (8 * cfg_addr[1:0]));
          if (cfg_addr == 8'h00 && !m_do) b = 8'h00;
          m_rdata <= {24'h0, b};
          m_rtag  <= (cfg_addr == 8'h00) ? "R4" : "R5";
        end else begin
          m_rdata <= w;
          m_rtag  <= "R5";
        end
      end
    end
  end

  // ---------------- every-cycle comparison on the falling edge --------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ee_cs === m_cs, "R2,R3 select pin", 32'(ee_cs), 32'(m_cs));
      chk(ee_sk === m_sk, "R2,R3 clock pin", 32'(ee_sk), 32'(m_sk));
      chk(ee_di === m_di, "R2,R3 serial-in pin", 32'(ee_di), 32'(m_di));
      chk(ee_do === m_do, "R8 serial out", 32'(ee_do), 32'(m_do));
      chk(image_ready === m_ready, "R6 image ready", 32'(image_ready), 32'(m_ready));
      chk(cfg_rvalid === m_rvalid, "R4 read valid", 32'(cfg_rvalid), 32'(m_rvalid));
      if (m_rvalid) chk(cfg_rdata === m_rdata, m_rtag, cfg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------------------------------
  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic bsel, output logic [31:0] r);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_rd_byte = bsel; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_rd_byte = 1'b0;
    r = cfg_rdata;
  endtask

  task automatic clk_bit(input logic b);
    cfg_write(8'h80, {24'h0, 1'b0, b, 6'h0});
    cfg_write(8'h80, {24'h0, 1'b1, b, 6'h0});
    @(negedge clk);
  endtask

  task automatic deselect();
    cfg_write(8'hC0, 32'h0);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a, input int lead);
    deselect();
    for (int i = 0; i < lead; i++) clk_bit(1'b0);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = 5; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic ser_read(input logic [5:0] a, input int lead, output logic [15:0] w);
    send_cmd(2'b10, a, lead);
    chk(ee_do === 1'b0, "R8 dummy bit", 32'(ee_do), 32'h0);
    w = 16'h0;
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0);
      w = {w[14:0], ee_do};
    end
    clk_bit(1'b0);
    chk(ee_do === 1'b1, "R8 output released after 16 bits", 32'(ee_do), 32'h1);
    deselect();
  endtask

  // ---------------- main sequence --------------------------------------------
  initial begin
    logic [31:0] r;
    logic [15:0] w, sum;
    repeat (3) @(negedge clk);
    chk(ee_cs === 0 && ee_sk === 0 && ee_di === 0, "R1 pins in reset",
        {29'h0, ee_cs, ee_sk, ee_di}, 32'h0);
    chk(cfg_rvalid === 0 && image_ready === 0, "R1 flags in reset",
        {30'h0, cfg_rvalid, image_ready}, 32'h0);
    chk(ee_do === 1'b1, "R1 serial out in reset", 32'(ee_do), 32'h1);
    rst = 1'b0;
    @(negedge clk);
    chk(image_ready === 1'b0, "R1 not ready after release", 32'(image_ready), 32'h0);
    repeat (70) @(negedge clk);
    chk(image_ready === 1'b1, "R6 ready after load", 32'(image_ready), 32'h1);

    // plain storage
    cfg_write(8'h00, 32'h1122_33C5);
    cfg_write(8'h14, 32'hDEAD_BEEF);
    cfg_write(8'h7C, 32'h0BAD_F00D);
    cfg_read(8'h14, 1'b0, r); chk(r === 32'hDEAD_BEEF, "R5 word read", r, 32'hDEAD_BEEF);
    cfg_read(8'h15, 1'b1, r); chk(r === 32'h0000_00BE, "R5 byte read", r, 32'h0000_00BE);
    cfg_read(8'h03, 1'b1, r); chk(r === 32'h0000_0011, "R5 top byte", r, 32'h0000_0011);
    cfg_read(8'h80, 1'b0, r); chk(r === 32'h0, "R5 pin dword reads zero", r, 32'h0);
    cfg_read(8'hC0, 1'b0, r); chk(r === 32'h0, "R5 pin dword reads zero", r, 32'h0);
    deselect();
    cfg_read(8'h7C, 1'b0, r); chk(r === 32'h0BAD_F00D, "R5 neighbour unchanged", r, 32'h0BAD_F00D);
    cfg_read(8'h00, 1'b1, r); chk(r === 32'h0000_00C5, "R4 ungated byte", r, 32'h0000_00C5);

    // gating: dummy bit 0 then word 63 bit 15 = 1
    send_cmd(2'b10, 6'd63, 0);
    cfg_read(8'h00, 1'b1, r); chk(r === 32'h0, "R4 gated byte while output low", r, 32'h0);
    cfg_read(8'h00, 1'b0, r); chk(r === 32'h1122_33C5, "R4 word read not gated", r, 32'h1122_33C5);
    clk_bit(1'b0);
    cfg_read(8'h00, 1'b1, r); chk(r === 32'h0000_00C5, "R4 byte passes while output high", r, 32'h0000_00C5);
    deselect();
    chk(ee_do === 1'b1, "R9 output high after deselect", 32'(ee_do), 32'h1);

    // non-read opcode is ignored
    send_cmd(2'b11, 6'd5, 0);
    for (int i = 0; i < 17; i++) begin
      clk_bit(1'b0);
      chk(ee_do === 1'b1, "R9 other opcode keeps output high", 32'(ee_do), 32'h1);
    end
    deselect();

    // abort mid-read, then a clean read with leading zeros
    send_cmd(2'b10, 6'd32, 0);
    clk_bit(1'b0); clk_bit(1'b0);
    deselect();
    chk(ee_do === 1'b1, "R9 abort releases output", 32'(ee_do), 32'h1);
    ser_read(6'd32, 3, w);
    chk(w === 16'h0F07, "R10 read after leading zeros", 32'(w), 32'h0F07);

    // whole image
    sum = 16'h0;
    for (int a = 0; a < 64; a++) begin
      ser_read(6'(a), 0, w);
      chk(w === img[a], "R8 serial word", 32'(w), 32'(img[a]));
      sum = sum + w;
      if (a == 0)  chk(w === 16'h0057, "R6 word 0", 32'(w), 32'h0057);
      if (a == 34) chk(w === 16'h0007, "R6 word 34", 32'(w), 32'h0007);
      if (a == 63) chk(w === 16'hF9B6, "R7 seal word", 32'(w), 32'hF9B6);
    end
    chk(sum === 16'h1234, "R7 word sum", 32'(sum), 32'h1234);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule